// File: doc/BRIEF.md
# Interprocessor Interrupt Dispatcher

This block turns a 64-bit interrupt command, written by the local processor, into delivery actions toward up to `NCPU` processors. Fixed interrupts come out as a vector with a target mask, and non-maskable interrupts as a target mask. The target set comes either from an explicit destination ID or from a shorthand: self, every active processor, or every active processor but self. Each result is a one-cycle pulse, registered one clock after the triggering write.

The block also holds a three-state boot sequencer for every processor: held in INIT, waiting for a startup command, and running. Only processor 0 can move another processor through these states. An accepted startup command emits a strobe with the target ID and a start address derived from the vector.

The command arrives in one of two ways. In the narrow addressing mode it comes as two 32-bit halves, and writing the low half sends it. In the extended addressing mode it comes as one 64-bit write. Any command the block cannot carry out raises a one-cycle `unhandled_o` pulse, so that a slower agent can take it over.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset all outputs are low. Processor 0 is running and every other processor is held in INIT.
- R2: In narrow mode (`ext_mode_i`=0), a high-half write only stores the word and produces no output. A low-half write sends the command built from the stored high half and the new low half, with the destination ID taken from command bits 63:56. If both are written in the same cycle, the send uses the previously stored high half.
- R3: In extended mode (`ext_mode_i`=1), a wide write sends the command and the destination ID is command bits 63:32. Half writes are ignored in this mode.
- R4: The command fields are: vector in bits 7:0, delivery mode in bits 10:8 (fixed 000, NMI 100, INIT 101, startup 110), level in bit 14, and shorthand in bits 19:18. A fixed command pulses `fix_valid_o` with the vector and the target mask one cycle after the send.
- R5: The shorthand selects the targets: 00 is the explicit destination, 01 is the local processor only, 10 is `active_i` including self, and 11 is `active_i` with self removed.
- R6: An NMI command pulses `nmi_valid_o` with the same target selection and does not raise `fix_valid_o`.
- R7: An INIT command with level 0 is dropped. It produces no output and changes no state.
- R8: An INIT command with level 1, sent by processor 0 to a destination in the range 1 to NCPU-1, moves that target from INIT to waiting. A target in any other state keeps its state. No output is produced.
- R9: A startup command from processor 0 to a destination in the range 1 to NCPU-1 is accepted only when that target is waiting. It then pulses `start_valid_o` with the target ID and the address vector<<12, and the target becomes running. Otherwise it is dropped with no output.
- R10: An INIT command with level 1, or a startup command, that comes from a processor other than 0, or names destination 0 or a destination at or above NCPU, pulses `unhandled_o`.
- R11: Any delivery mode other than the four listed pulses `unhandled_o`. At most one result output pulses per cycle.
- R12: For fixed or NMI delivery, an explicit destination at or above NCPU gives a valid pulse with an empty target mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_mode_i | input | 1 | 1 selects the extended addressing format |
| local_id_i | input | ID_W | ID of the issuing processor |
| active_i | input | NCPU | Mask of active processors |
| wr_hi_i | input | 1 | Narrow-mode write of the high half |
| wr_lo_i | input | 1 | Narrow-mode write of the low half (sends) |
| wr_data_i | input | 32 | Data for half writes |
| wr_wide_i | input | 1 | Extended-mode 64-bit write (sends) |
| wide_data_i | input | 64 | Data for wide writes |
| fix_valid_o | output | 1 | Fixed interrupt request pulse |
| fix_vector_o | output | 8 | Vector of the fixed interrupt |
| fix_mask_o | output | NCPU | Targets of the fixed interrupt |
| nmi_valid_o | output | 1 | NMI request pulse |
| nmi_mask_o | output | NCPU | Targets of the NMI |
| start_valid_o | output | 1 | Accepted startup strobe |
| start_id_o | output | ID_W | Processor being started |
| start_addr_o | output | 20 | Start address, vector<<12 |
| unhandled_o | output | 1 | Command not carried out here |

## Verification
A boot sequencer stuck in the wrong state never shows up directly at the ports. It only appears at the next startup command to that processor, as a strobe that should have been dropped or as silence where a strobe was due. For that reason, every INIT step in the bench is followed by a startup probe. Errors in the captured high half or in the destination decode show up one cycle after the low-half or wide write, as a wrong `fix_mask_o` or `nmi_mask_o`. A dropped command with level 0 is checked the same way: by the absence of an output, and by a later probe showing that the target is still held.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    BOOT_HELD = 2'd0,
    BOOT_WAIT = 2'd1,
    BOOT_RUN  = 2'd2
  } boot_t;

  localparam logic [2:0] DM_FIXED = 3'b000;
  localparam logic [2:0] DM_NMI   = 3'b100;
  localparam logic [2:0] DM_INIT  = 3'b101;
  localparam logic [2:0] DM_START = 3'b110;

  localparam logic [1:0] SH_DEST     = 2'b00;
  localparam logic [1:0] SH_SELF     = 2'b01;
  localparam logic [1:0] SH_ALL      = 2'b10;
  localparam logic [1:0] SH_ALL_XSELF = 2'b11;

  localparam int ADDR_W = 20;

  function automatic logic [7:0] f_vector(input logic [63:0] c);
    return c[7:0];
  endfunction

  function automatic logic [2:0] f_mode(input logic [63:0] c);
    return c[10:8];
  endfunction

  function automatic logic f_level(input logic [63:0] c);
    return c[14];
  endfunction

  function automatic logic [1:0] f_short(input logic [63:0] c);
    return c[19:18];
  endfunction

  // destination ID: top byte in narrow mode, top word in extended mode
  function automatic logic [31:0] f_dest(input logic [63:0] c, input logic ext);
    return ext ? c[63:32] : {24'd0, c[63:56]};
  endfunction

  function automatic logic [ADDR_W-1:0] f_start_addr(input logic [7:0] v);
    return {v, 12'h000};
  endfunction
endpackage

// File: rtl/ipi_cmd_capture.sv
module ipi_cmd_capture (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext_mode_i,
  input  logic        wr_hi_i,
  input  logic        wr_lo_i,
  input  logic [31:0] wr_data_i,
  input  logic        wr_wide_i,
  input  logic [63:0] wide_data_i,
  output logic        send_o,
  output logic [63:0] cmd_o
);
  logic [31:0] hi_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                    hi_q <= '0;
    else if (!ext_mode_i && wr_hi_i) hi_q <= wr_data_i;
  end

  always_comb begin
    if (ext_mode_i) begin
      send_o = wr_wide_i;
      cmd_o  = wide_data_i;
    end else begin
      send_o = wr_lo_i;
      cmd_o  = {hi_q, wr_data_i};
    end
  end

  // R3: extended-mode traffic never disturbs the stored high half
  p_hi_kept_in_ext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mode_i |=> $stable(hi_q));
endmodule

// File: rtl/ipi_fanout.sv
module ipi_fanout #(
  parameter int NCPU = 8,
  localparam int ID_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      short_i,
  input  logic [31:0]     dest_i,
  input  logic [ID_W-1:0] local_id_i,
  input  logic [NCPU-1:0] active_i,
  output logic [NCPU-1:0] tgt_o
);
  import ipi_pkg::*;

  logic [NCPU-1:0] self_mask;
  logic [NCPU-1:0] dest_mask;

  for (genvar i = 0; i < NCPU; i++) begin : g_bit
    assign self_mask[i] = (local_id_i == ID_W'(i));
    assign dest_mask[i] = (dest_i == 32'(i));
  end

  always_comb begin
    unique case (short_i)
      SH_DEST:  tgt_o = dest_mask;
      SH_SELF:  tgt_o = self_mask;
      SH_ALL:   tgt_o = active_i;
      default:  tgt_o = active_i & ~self_mask;
    endcase
  end

  // R5: excluding shorthand never names the issuer
  p_xself_excludes_issuer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_i == SH_ALL_XSELF) |-> ((tgt_o & self_mask) == '0));
  // R12: out-of-range explicit destination yields no target
  p_far_dest_empty_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_i == SH_DEST && dest_i >= 32'(NCPU)) |-> (tgt_o == '0));
endmodule

// File: rtl/ipi_boot_seq.sv
module ipi_boot_seq #(
  parameter int NCPU = 8,
  localparam int ID_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] sel_i,
  input  logic            init_hit_i,
  input  logic            start_hit_i,
  output ipi_pkg::boot_t  sel_state_o
);
  import ipi_pkg::*;

  boot_t st_q [NCPU];

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    localparam boot_t RST_ST = (i == 0) ? BOOT_RUN : BOOT_HELD;
    logic picked;
    assign picked = (sel_i == ID_W'(i));

    always_ff @(posedge clk_i) begin
      if (!rst_ni) st_q[i] <= RST_ST;
      else if (picked && init_hit_i && st_q[i] == BOOT_HELD) st_q[i] <= BOOT_WAIT;
      else if (picked && start_hit_i && st_q[i] == BOOT_WAIT) st_q[i] <= BOOT_RUN;
    end

    // R9: a running processor stays running
    p_run_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] == BOOT_RUN) |=> (st_q[i] == BOOT_RUN));
    // R8: waiting is only entered through an accepted INIT
    p_wait_via_init_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] == BOOT_HELD) |=> (st_q[i] != BOOT_RUN));
  end

  always_comb begin
    sel_state_o = BOOT_HELD;
    for (int k = 0; k < NCPU; k++)
      if (sel_i == ID_W'(k)) sel_state_o = st_q[k];
  end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int NCPU = 8,
  localparam int ID_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_mode_i,
  input  logic [ID_W-1:0] local_id_i,
  input  logic [NCPU-1:0] active_i,
  input  logic            wr_hi_i,
  input  logic            wr_lo_i,
  input  logic [31:0]     wr_data_i,
  input  logic            wr_wide_i,
  input  logic [63:0]     wide_data_i,
  output logic            fix_valid_o,
  output logic [7:0]      fix_vector_o,
  output logic [NCPU-1:0] fix_mask_o,
  output logic            nmi_valid_o,
  output logic [NCPU-1:0] nmi_mask_o,
  output logic            start_valid_o,
  output logic [ID_W-1:0] start_id_o,
  output logic [19:0]     start_addr_o,
  output logic            unhandled_o
);
  import ipi_pkg::*;

  logic            send;
  logic [63:0]     cmd;
  logic [31:0]     dest;
  logic [2:0]      mode;
  logic [NCPU-1:0] tgt;
  logic            dest_ok;
  logic [ID_W-1:0] sel_id;
  boot_t           sel_state;

  // named events, visible to the assertions
  logic ev_fixed, ev_nmi, ev_init_hit, ev_start_hit, ev_init_drop, ev_unhandled;

  ipi_cmd_capture u_cap (
    .clk_i, .rst_ni, .ext_mode_i, .wr_hi_i, .wr_lo_i, .wr_data_i,
    .wr_wide_i, .wide_data_i, .send_o(send), .cmd_o(cmd)
  );

  assign dest = f_dest(cmd, ext_mode_i);
  assign mode = f_mode(cmd);

  ipi_fanout #(.NCPU(NCPU)) u_fan (
    .clk_i, .rst_ni, .short_i(f_short(cmd)), .dest_i(dest),
    .local_id_i, .active_i, .tgt_o(tgt)
  );

  assign dest_ok = (local_id_i == '0) && (dest != 32'd0) && (dest < 32'(NCPU));
  assign sel_id  = dest[ID_W-1:0];

  ipi_boot_seq #(.NCPU(NCPU)) u_boot (
    .clk_i, .rst_ni, .sel_i(sel_id), .init_hit_i(ev_init_hit),
    .start_hit_i(ev_start_hit), .sel_state_o(sel_state)
  );

  always_comb begin
    ev_fixed     = send && (mode == DM_FIXED);
    ev_nmi       = send && (mode == DM_NMI);
    ev_init_drop = send && (mode == DM_INIT) && !f_level(cmd);
    ev_init_hit  = send && (mode == DM_INIT) && f_level(cmd) && dest_ok;
    ev_start_hit = send && (mode == DM_START) && dest_ok && (sel_state == BOOT_WAIT);
    ev_unhandled = send && !ev_fixed && !ev_nmi && !ev_init_drop && !ev_init_hit
                   && !((mode == DM_START) && dest_ok);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fix_valid_o   <= 1'b0;
      fix_vector_o  <= '0;
      fix_mask_o    <= '0;
      nmi_valid_o   <= 1'b0;
      nmi_mask_o    <= '0;
      start_valid_o <= 1'b0;
      start_id_o    <= '0;
      start_addr_o  <= '0;
      unhandled_o   <= 1'b0;
    end else begin
      fix_valid_o   <= ev_fixed;
      fix_vector_o  <= ev_fixed ? f_vector(cmd) : '0;
      fix_mask_o    <= ev_fixed ? tgt : '0;
      nmi_valid_o   <= ev_nmi;
      nmi_mask_o    <= ev_nmi ? tgt : '0;
      start_valid_o <= ev_start_hit;
      start_id_o    <= ev_start_hit ? sel_id : '0;
      start_addr_o  <= ev_start_hit ? f_start_addr(f_vector(cmd)) : '0;
      unhandled_o   <= ev_unhandled;
    end
  end

  // R11: one result kind at a time
  p_single_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fix_valid_o, nmi_valid_o, start_valid_o, unhandled_o}));
  // R2: results follow a sending write by one cycle
  p_result_needs_send_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_valid_o || nmi_valid_o || start_valid_o || unhandled_o)
      |-> $past(wr_lo_i || wr_wide_i));
  // R9: processor 0 is never the target of a startup
  p_start_not_bsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_o |-> (start_id_o != '0));
  // R7: a dropped INIT leaves every output quiet next cycle
  p_init_drop_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_init_drop |=> !(fix_valid_o || nmi_valid_o || start_valid_o || unhandled_o));
endmodule

// File: tb/test_ipi_dispatch.sv
`timescale 1ns/1ps
module test_ipi_dispatch;
  localparam int NCPU = 8;
  localparam int ID_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_mode = 1'b0;
  logic [ID_W-1:0] local_id = '0;
  logic [NCPU-1:0] active = 8'hFF;
  logic wr_hi = 1'b0, wr_lo = 1'b0, wr_wide = 1'b0;
  logic [31:0] wr_data = '0;
  logic [63:0] wide_data = '0;
  logic fix_valid, nmi_valid, start_valid, unhandled;
  logic [7:0] fix_vector;
  logic [NCPU-1:0] fix_mask, nmi_mask;
  logic [ID_W-1:0] start_id;
  logic [19:0] start_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ipi_dispatch #(.NCPU(NCPU)) i_ipi_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .local_id_i(local_id),
    .active_i(active), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wr_data_i(wr_data),
    .wr_wide_i(wr_wide), .wide_data_i(wide_data),
    .fix_valid_o(fix_valid), .fix_vector_o(fix_vector), .fix_mask_o(fix_mask),
    .nmi_valid_o(nmi_valid), .nmi_mask_o(nmi_mask),
    .start_valid_o(start_valid), .start_id_o(start_id), .start_addr_o(start_addr),
    .unhandled_o(unhandled)
  );

  function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] md,
                                          input logic lvl, input logic [1:0] sh);
    logic [31:0] w = '0;
    w[7:0] = vec; w[10:8] = md; w[14] = lvl; w[19:18] = sh;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // result snapshot packed: {fixv,vec,fmask,nmiv,nmask,stv,sid,saddr,unh}
  function automatic logic [63:0] snap();
    return {fix_valid, fix_vector, fix_mask, nmi_valid, nmi_mask,
            start_valid, start_id, start_addr, unhandled};
  endfunction

  task automatic expect_quiet(input string req);
    chk(snap() == '0, req, snap(), 64'h0);
  endtask

  task automatic w_hi(input logic [31:0] d);
    wr_hi = 1'b1; wr_data = d;
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic w_lo(input logic [31:0] d);
    wr_lo = 1'b1; wr_data = d;
    @(negedge clk); wr_lo = 1'b0;
  endtask

  task automatic w_wide(input logic [63:0] d);
    wr_wide = 1'b1; wide_data = d;
    @(negedge clk); wr_wide = 1'b0;
  endtask

  task automatic send_narrow(input logic [7:0] dst, input logic [31:0] lo);
    w_hi({dst, 24'h0});
    w_lo(lo);
  endtask

  task automatic t_reset();
    expect_quiet("R1 outputs after reset");
  endtask

  task automatic t_legacy();
    ext_mode = 1'b0; local_id = 3'd0;
    w_hi(32'h0300_0000);
    expect_quiet("R2 high write alone");
    w_lo(lo_word(8'h41, 3'b000, 1'b0, 2'b00));
    chk(fix_valid && fix_vector == 8'h41 && fix_mask == 8'h08 && !nmi_valid,
        "R4 fixed to dest 3", {fix_valid, fix_vector, fix_mask}, {1'b1, 8'h41, 8'h08});
    // R2: stored high half reused by a second low write
    w_lo(lo_word(8'h42, 3'b000, 1'b0, 2'b00));
    chk(fix_mask == 8'h08 && fix_vector == 8'h42, "R2 stored high reused",
        {fix_vector, fix_mask}, {8'h42, 8'h08});
  endtask

  task automatic t_shorthand();
    ext_mode = 1'b0; local_id = 3'd2; active = 8'hB5;
    send_narrow(8'h07, lo_word(8'h50, 3'b000, 1'b0, 2'b01));
    chk(fix_mask == 8'h04, "R5 self", fix_mask, 8'h04);
    send_narrow(8'h07, lo_word(8'h50, 3'b000, 1'b0, 2'b10));
    chk(fix_mask == 8'hB5, "R5 all incl self", fix_mask, 8'hB5);
    send_narrow(8'h07, lo_word(8'h50, 3'b000, 1'b0, 2'b11));
    chk(fix_mask == 8'hB1, "R5 all excl self", fix_mask, 8'hB1);
    send_narrow(8'h07, lo_word(8'h50, 3'b000, 1'b0, 2'b00));
    chk(fix_mask == 8'h80, "R5 explicit dest 7", fix_mask, 8'h80);
  endtask

  task automatic t_nmi();
    ext_mode = 1'b0; local_id = 3'd2; active = 8'hB5;
    send_narrow(8'h00, lo_word(8'h00, 3'b100, 1'b0, 2'b11));
    chk(nmi_valid && nmi_mask == 8'hB1 && !fix_valid, "R6 nmi excl self",
        {fix_valid, nmi_valid, nmi_mask}, {1'b0, 1'b1, 8'hB1});
    send_narrow(8'h01, lo_word(8'h00, 3'b100, 1'b0, 2'b00));
    chk(nmi_valid && nmi_mask == 8'h02, "R6 nmi dest 1", nmi_mask, 8'h02);
  endtask

  task automatic t_extended();
    ext_mode = 1'b1; local_id = 3'd0; active = 8'hFF;
    w_wide({32'd5, lo_word(8'h61, 3'b000, 1'b0, 2'b00)});
    chk(fix_valid && fix_mask == 8'h20 && fix_vector == 8'h61, "R3 wide dest 5",
        {fix_valid, fix_vector, fix_mask}, {1'b1, 8'h61, 8'h20});
    w_lo(lo_word(8'h61, 3'b000, 1'b0, 2'b10));
    expect_quiet("R3 half write ignored in ext mode");
    w_wide({32'd256, lo_word(8'h62, 3'b000, 1'b0, 2'b00)});
    chk(fix_valid && fix_mask == 8'h00, "R12 ext dest 256 empty",
        {fix_valid, fix_mask}, {1'b1, 8'h00});
    ext_mode = 1'b0;
    send_narrow(8'hFF, lo_word(8'h63, 3'b000, 1'b0, 2'b00));
    chk(fix_valid && fix_mask == 8'h00, "R12 narrow dest 255 empty",
        {fix_valid, fix_mask}, {1'b1, 8'h00});
  endtask

  task automatic t_boot();
    ext_mode = 1'b0; local_id = 3'd0;
    send_narrow(8'h01, lo_word(8'h9A, 3'b110, 1'b0, 2'b00));
    expect_quiet("R9 startup before INIT dropped");
    send_narrow(8'h01, lo_word(8'h00, 3'b101, 1'b0, 2'b00));
    expect_quiet("R7 INIT level 0 silent");
    send_narrow(8'h01, lo_word(8'h9A, 3'b110, 1'b0, 2'b00));
    expect_quiet("R7 state unchanged after level-0 INIT");
    send_narrow(8'h01, lo_word(8'h00, 3'b101, 1'b1, 2'b00));
    expect_quiet("R8 INIT accepted silently");
    send_narrow(8'h01, lo_word(8'h9A, 3'b110, 1'b0, 2'b00));
    chk(start_valid && start_id == 3'd1 && start_addr == 20'h9A000 && !unhandled,
        "R9 startup accepted", {start_valid, start_id, start_addr}, {1'b1, 3'd1, 20'h9A000});
    send_narrow(8'h01, lo_word(8'h9B, 3'b110, 1'b0, 2'b00));
    expect_quiet("R9 second startup dropped");
    send_narrow(8'h01, lo_word(8'h00, 3'b101, 1'b1, 2'b00));
    send_narrow(8'h01, lo_word(8'h9C, 3'b110, 1'b0, 2'b00));
    expect_quiet("R8 INIT does not pull running cpu back");
    // extended-mode boot of cpu 6
    ext_mode = 1'b1;
    w_wide({32'd6, lo_word(8'h00, 3'b101, 1'b1, 2'b00)});
    w_wide({32'd6, lo_word(8'h10, 3'b110, 1'b0, 2'b00)});
    chk(start_valid && start_id == 3'd6 && start_addr == 20'h10000, "R9 ext startup cpu 6",
        {start_valid, start_id, start_addr}, {1'b1, 3'd6, 20'h10000});
    ext_mode = 1'b0;
  endtask

  task automatic t_unhandled();
    ext_mode = 1'b0;
    local_id = 3'd3;
    send_narrow(8'h02, lo_word(8'h00, 3'b101, 1'b1, 2'b00));
    chk(unhandled && !start_valid, "R10 INIT from non-bsp", unhandled, 1);
    send_narrow(8'h02, lo_word(8'h20, 3'b110, 1'b0, 2'b00));
    chk(unhandled, "R10 startup from non-bsp", unhandled, 1);
    local_id = 3'd0;
    send_narrow(8'h02, lo_word(8'h20, 3'b110, 1'b0, 2'b00));
    expect_quiet("R10 cpu 2 still held after foreign INIT");
    send_narrow(8'h00, lo_word(8'h00, 3'b101, 1'b1, 2'b00));
    chk(unhandled, "R10 INIT to dest 0", unhandled, 1);
    send_narrow(8'h08, lo_word(8'h00, 3'b101, 1'b1, 2'b00));
    chk(unhandled, "R10 INIT to dest 8", unhandled, 1);
    send_narrow(8'h01, lo_word(8'h00, 3'b010, 1'b0, 2'b00));
    chk(unhandled && !fix_valid && !nmi_valid, "R11 mode 010", unhandled, 1);
    send_narrow(8'h01, lo_word(8'h00, 3'b111, 1'b0, 2'b00));
    chk(unhandled, "R11 mode 111", unhandled, 1);
    @(negedge clk);
    expect_quiet("R11 pulse lasts one cycle");
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legacy();
    t_shorthand();
    t_nmi();
    t_extended();
    t_boot();
    t_unhandled();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule